// File: doc/BRIEF.md
# Serial Receiver with Line-Break Recognition

This block is an asynchronous serial receiver. It runs on the system clock and advances on a 16x oversampling enable. The line input is resynchronised first. A falling edge is confirmed at the middle of the start bit. After that, eight data bits are taken least significant bit first, then an optional even or odd parity bit, then one stop bit. Each bit is sampled once, at its midpoint. At the stop sample the receiver emits one character word on a single-cycle push strobe. The word holds the data byte plus three flags: parity error, framing error and received break. A downstream buffer takes these words.

A line held low for a whole frame, stop bit included, is reported as a zero byte with the break flag set. A line that drops low partway through a frame works differently. The receiver first emits the damaged frame with its error flags. If the line then stays low for one further full frame time, it emits the break character as well. After any break the line must be high for half a bit time before the next start bit can be accepted. Reset leaves the receiver in that same wait-for-high condition.

Top module: `uart_brk_rx`

## Requirements
- R1: While reset is asserted, push is 0 and push_data is 0. After reset, a line held low produces no character until the line has been high for at least 8 oversampling ticks.
- R2: A valid frame (start low, 8 data bits LSB first, optional parity, stop high) produces exactly one push. It carries the data byte with parity, framing and break flags all 0. Two pushes never occur on consecutive cycles.
- R3: With parity enabled and even parity selected (par_odd=0), the expected parity bit makes the count of ones over data plus parity even. With odd parity selected (par_odd=1), that count is odd. A mismatch sets push_pe and still delivers the data byte.
- R4: A stop bit sampled low sets push_fe when any data bit or the parity bit was 1. The byte is still delivered, and push_rb is 0.
- R5: A frame in which every data bit, the parity bit (if enabled) and the stop bit are low produces one push with push_data=0, push_rb=1, push_pe=0 and push_fe=0. Holding the line low for longer produces no further push.
- R6: After a break, no start bit is accepted until the line has been high for 8 consecutive ticks. A shorter high pulse followed by low produces no character.
- R7: If the line goes low partway through a frame and stays low through the stop bit and one more full frame time (10 bit times without parity, 11 with parity), two pushes occur in order. The first is the damaged frame with its error flags. The second is the break character.
- R8: If, after a framing error, the line returns high before one full frame time has elapsed, only the damaged frame is pushed and no break character follows.
- R9: A low pulse on the idle line that is high again at the mid-start sample point (8 ticks after the falling edge) is ignored and produces no push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit time |
| rxd | input | 1 | Asynchronous serial line, idle high |
| par_en | input | 1 | 1 enables a parity bit after the data bits |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| push | output | 1 | One-cycle strobe: a character word is valid |
| push_data | output | 8 | Received byte (zero for a break character) |
| push_pe | output | 1 | Parity error flag of the word |
| push_fe | output | 1 | Framing error flag of the word |
| push_rb | output | 1 | Received break flag of the word |

## Verification
The stop-bit sample is the point where two functions meet in one cycle. In that cycle the receiver must deliver the damaged character with its framing and parity flags, and it must also start timing a possible break. The bench provokes this by driving a few data bits high and then holding the line low through the stop bit. One variant keeps the line low well past a further frame time and expects two words in order: the damaged byte, then the zero break word. The other variant releases the line early and expects the damaged word alone.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_WAITHI,
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_WATCH
  } rx_state_e;

  typedef struct packed {
    logic rb;
    logic fe;
    logic pe;
  } rx_flags_t;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_n;

  always_comb begin
    pipe_n = {pipe_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
    end else begin
      pipe_q <= pipe_n;
    end
  end

  assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/rx_parity.sv
module rx_parity #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data,
  input  logic             odd,
  output logic             exp_bit
);

  always_comb begin
    exp_bit = (^data) ^ odd;
  end

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rxd_s,
  input  logic                 par_en,
  input  logic                 par_exp,
  output logic [DATA_BITS-1:0] shreg,
  output logic                 push_o,
  output logic [DATA_BITS-1:0] data_o,
  output rx_flags_t            flags_o
);

  localparam int CW      = $clog2(OSR);
  localparam int HALF    = OSR / 2;
  localparam int BW      = $clog2(DATA_BITS);
  localparam int FRAME_N = (DATA_BITS + 2) * OSR;
  localparam int FRAME_P = FRAME_N + OSR;
  localparam int FCW     = $clog2(FRAME_P);

  rx_state_e            state_q, state_n;
  logic [CW-1:0]        tcnt_q, tcnt_n;
  logic [CW-1:0]        hcnt_q, hcnt_n;
  logic [BW-1:0]        bidx_q, bidx_n;
  logic [FCW-1:0]       fcnt_q, fcnt_n;
  logic [DATA_BITS-1:0] sh_q, sh_n;
  logic                 pbit_q, pbit_n;
  logic                 push_q, push_n;
  logic [DATA_BITS-1:0] dout_q, dout_n;
  rx_flags_t            flg_q, flg_n;
  logic                 bit_end;
  logic                 content_zero;
  logic [FCW-1:0]       frame_lim;

  assign shreg = sh_q;

  always_comb begin
    bit_end      = (tcnt_q == CW'(OSR - 1));
    content_zero = (sh_q == '0) && (!par_en || !pbit_q);
    frame_lim    = par_en ? FCW'(FRAME_P - 1) : FCW'(FRAME_N - 1);
  end

  always_comb begin
    state_n = state_q;
    tcnt_n  = tcnt_q;
    hcnt_n  = hcnt_q;
    bidx_n  = bidx_q;
    fcnt_n  = fcnt_q;
    sh_n    = sh_q;
    pbit_n  = pbit_q;
    push_n  = 1'b0;
    dout_n  = dout_q;
    flg_n   = flg_q;
    if (tick) begin
      case (state_q)
        RX_WAITHI: begin
          if (rxd_s) begin
            if (hcnt_q == CW'(HALF - 1)) begin
              hcnt_n  = '0;
              state_n = RX_IDLE;
            end else begin
              hcnt_n = hcnt_q + 1'b1;
            end
          end else begin
            hcnt_n = '0;
          end
        end
        RX_IDLE: begin
          if (!rxd_s) begin
            tcnt_n  = '0;
            state_n = RX_START;
          end
        end
        RX_START: begin
          if (tcnt_q == CW'(HALF - 1)) begin
            tcnt_n = '0;
            bidx_n = '0;
            state_n = rxd_s ? RX_IDLE : RX_DATA;
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            tcnt_n = '0;
            sh_n   = {rxd_s, sh_q[DATA_BITS-1:1]};
            if (bidx_q == BW'(DATA_BITS - 1)) begin
              state_n = par_en ? RX_PAR : RX_STOP;
            end else begin
              bidx_n = bidx_q + 1'b1;
            end
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (bit_end) begin
            tcnt_n  = '0;
            pbit_n  = rxd_s;
            state_n = RX_STOP;
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_end) begin
            tcnt_n = '0;
            push_n = 1'b1;
            if (!rxd_s && content_zero) begin
              dout_n  = '0;
              flg_n   = '{rb: 1'b1, fe: 1'b0, pe: 1'b0};
              hcnt_n  = '0;
              state_n = RX_WAITHI;
            end else begin
              dout_n   = sh_q;
              flg_n.rb = 1'b0;
              flg_n.fe = !rxd_s;
              flg_n.pe = par_en && (pbit_q != par_exp);
              fcnt_n   = '0;
              state_n  = rxd_s ? RX_IDLE : RX_WATCH;
            end
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
        RX_WATCH: begin
          if (rxd_s) begin
            hcnt_n  = '0;
            state_n = RX_WAITHI;
          end else if (fcnt_q == frame_lim) begin
            push_n  = 1'b1;
            dout_n  = '0;
            flg_n   = '{rb: 1'b1, fe: 1'b0, pe: 1'b0};
            hcnt_n  = '0;
            state_n = RX_WAITHI;
          end else begin
            fcnt_n = fcnt_q + 1'b1;
          end
        end
        default: begin
          hcnt_n  = '0;
          state_n = RX_WAITHI;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_WAITHI;
      tcnt_q  <= '0;
      hcnt_q  <= '0;
      bidx_q  <= '0;
      fcnt_q  <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      push_q  <= 1'b0;
      dout_q  <= '0;
      flg_q   <= '0;
    end else begin
      state_q <= state_n;
      tcnt_q  <= tcnt_n;
      hcnt_q  <= hcnt_n;
      bidx_q  <= bidx_n;
      fcnt_q  <= fcnt_n;
      sh_q    <= sh_n;
      pbit_q  <= pbit_n;
      push_q  <= push_n;
      dout_q  <= dout_n;
      flg_q   <= flg_n;
    end
  end

  assign push_o  = push_q;
  assign data_o  = dout_q;
  assign flags_o = flg_q;

  // R2
  single_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |=> !push_q);

  // R5
  brk_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_q && flg_q.rb) |-> (dout_q == '0 && !flg_q.pe && !flg_q.fe));

  // R4
  fe_not_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_q && flg_q.fe) |-> !flg_q.rb);

  // R6
  hunt_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == RX_WAITHI && state_q == RX_IDLE) |-> $past(rxd_s));

  // R9
  start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == RX_START && state_q == RX_DATA) |-> !$past(rxd_s));

endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_tick,
  input  logic                 rxd,
  input  logic                 par_en,
  input  logic                 par_odd,
  output logic                 push,
  output logic [DATA_BITS-1:0] push_data,
  output logic                 push_pe,
  output logic                 push_fe,
  output logic                 push_rb
);

  logic                 rxd_s;
  logic                 par_exp;
  logic [DATA_BITS-1:0] shreg;
  rx_flags_t            flags;

  rx_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (rxd_s)
  );

  rx_parity #(
    .WIDTH(DATA_BITS)
  ) u_par (
    .data   (shreg),
    .odd    (par_odd),
    .exp_bit(par_exp)
  );

  rx_frame_fsm #(
    .DATA_BITS(DATA_BITS),
    .OSR      (OSR)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (os_tick),
    .rxd_s  (rxd_s),
    .par_en (par_en),
    .par_exp(par_exp),
    .shreg  (shreg),
    .push_o (push),
    .data_o (push_data),
    .flags_o(flags)
  );

  assign push_pe = flags.pe;
  assign push_fe = flags.fe;
  assign push_rb = flags.rb;

endmodule

// File: tb/test_uart_brk_rx.sv
module test_uart_brk_rx;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, os_tick, rxd, par_en, par_odd;
  logic       push, push_pe, push_fe, push_rb;
  logic [7:0] push_data;

  int n_chk = 0;
  int n_err = 0;
  int pcount = 0;
  logic [10:0] plog [0:15];

  uart_brk_rx i_uart_brk_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .os_tick  (os_tick),
    .rxd      (rxd),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .push     (push),
    .push_data(push_data),
    .push_pe  (push_pe),
    .push_fe  (push_fe),
    .push_rb  (push_rb)
  );

  always @(negedge clk) begin
    if (rst_n && push) begin
      plog[pcount % 16] <= {push_rb, push_fe, push_pe, push_data};
      pcount <= pcount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] d, input bit use_par, input bit pv, input bit stop);
    drive(1'b0, 16);
    for (int i = 0; i < 8; i++) drive(d[i], 16);
    if (use_par) drive(pv, 16);
    drive(stop, 16);
  endtask

  task automatic expect_word(input string req, input int idx, input logic [7:0] d,
                             input bit pe, input bit fe, input bit rb);
    logic [10:0] exp;
    exp = {rb, fe, pe, d};
    check(plog[idx % 16] == exp, req, 32'(plog[idx % 16]), 32'(exp));
  endtask

  task automatic expect_count(input string req, input int want);
    check(pcount == want, req, pcount, want);
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int base;
    logic [7:0] d;
    bit wrong;
    rst_n   = 1'b0;
    os_tick = 1'b1;
    rxd     = 1'b0;
    par_en  = 1'b0;
    par_odd = 1'b0;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(push == 1'b0, "R1 push in reset", push, 0);
    check(push_data == 8'h00, "R1 data in reset", push_data, 0);
    rst_n = 1'b1;
    // R1: low line after reset yields nothing
    drive(1'b0, 300);
    expect_count("R1 no word from low line after reset", 0);
    drive(1'b1, 24);
    base = pcount;
    frame(8'hC3, 0, 0, 1);
    drive(1'b1, 4);
    expect_count("R1 first frame after high count", base + 1);
    expect_word("R1 first frame after high", base, 8'hC3, 0, 0, 0);

    // R2: exhaustive sweep without parity
    for (int i = 0; i < 256; i++) begin
      base = pcount;
      frame(8'(i), 0, 0, 1);
      drive(1'b1, 4);
      expect_count("R2 one push per frame", base + 1);
      expect_word("R2 data LSB first", base, 8'(i), 0, 0, 0);
    end

    // R3: even parity, some frames with a wrong parity bit
    par_en  = 1'b1;
    par_odd = 1'b0;
    for (int i = 0; i < 128; i++) begin
      d     = 8'(i * 37);
      wrong = (i % 4) >= 2;
      base  = pcount;
      frame(d, 1, (^d) ^ wrong, 1);
      drive(1'b1, 4);
      expect_count("R3 even parity count", base + 1);
      expect_word("R3 even parity flag", base, d, wrong, 0, 0);
    end
    // R3: odd parity
    par_odd = 1'b1;
    for (int i = 0; i < 128; i++) begin
      d     = 8'(i * 37 + 11);
      wrong = (i % 4) == 1;
      base  = pcount;
      frame(d, 1, (~^d) ^ wrong, 1);
      drive(1'b1, 4);
      expect_count("R3 odd parity count", base + 1);
      expect_word("R3 odd parity flag", base, d, wrong, 0, 0);
    end

    // R4: framing error with nonzero data, no parity
    par_en = 1'b0;
    base = pcount;
    frame(8'h5A, 0, 0, 0);
    drive(1'b1, 40);
    expect_count("R4 framing error count", base + 1);
    expect_word("R4 framing error word", base, 8'h5A, 0, 1, 0);
    // R4: zero data but parity bit 1 under even parity is not a break
    par_en  = 1'b1;
    par_odd = 1'b0;
    base = pcount;
    frame(8'h00, 1, 1, 0);
    drive(1'b1, 40);
    expect_count("R4 zero data parity high count", base + 1);
    expect_word("R4 zero data parity high word", base, 8'h00, 1, 1, 0);

    // R5: full break without parity, held long
    par_en = 1'b0;
    base = pcount;
    drive(1'b0, 16 * 30);
    expect_count("R5 single break word", base + 1);
    expect_word("R5 break word", base, 8'h00, 0, 0, 1);
    // R6: short high pulses do not re-arm the receiver
    drive(1'b1, 4);
    drive(1'b0, 40);
    drive(1'b1, 4);
    drive(1'b0, 200);
    expect_count("R6 no word after short high", base + 1);
    drive(1'b1, 24);
    base = pcount;
    frame(8'h3C, 0, 0, 1);
    drive(1'b1, 4);
    expect_count("R6 frame after half bit high count", base + 1);
    expect_word("R6 frame after half bit high", base, 8'h3C, 0, 0, 0);

    // R5: full break with odd parity
    par_en  = 1'b1;
    par_odd = 1'b1;
    base = pcount;
    drive(1'b0, 16 * 30);
    drive(1'b1, 24);
    expect_count("R5 odd parity break count", base + 1);
    expect_word("R5 odd parity break word", base, 8'h00, 0, 0, 1);

    // R7: break starting mid frame, no parity
    par_en = 1'b0;
    base = pcount;
    drive(1'b0, 16);
    drive(1'b1, 64);
    drive(1'b0, 16 * 20);
    drive(1'b1, 24);
    expect_count("R7 two words", base + 2);
    expect_word("R7 damaged word first", base, 8'h0F, 0, 1, 0);
    expect_word("R7 break word second", base + 1, 8'h00, 0, 0, 1);
    // R7: mid-frame break with even parity, parity also wrong
    par_en  = 1'b1;
    par_odd = 1'b0;
    base = pcount;
    drive(1'b0, 16);
    drive(1'b1, 48);
    drive(1'b0, 16 * 22);
    drive(1'b1, 24);
    expect_count("R7 parity two words", base + 2);
    expect_word("R7 parity damaged word", base, 8'h07, 1, 1, 0);
    expect_word("R7 parity break word", base + 1, 8'h00, 0, 0, 1);

    // R8: low ends before a frame time has passed
    par_en = 1'b0;
    base = pcount;
    drive(1'b0, 16);
    drive(1'b1, 64);
    drive(1'b0, 128);
    drive(1'b1, 200);
    expect_count("R8 damaged word only", base + 1);
    expect_word("R8 damaged word", base, 8'h0F, 0, 1, 0);
    base = pcount;
    frame(8'h96, 0, 0, 1);
    drive(1'b1, 4);
    expect_word("R8 recovery frame", base, 8'h96, 0, 0, 0);

    // R9: start glitches
    base = pcount;
    drive(1'b0, 4);
    drive(1'b1, 40);
    drive(1'b0, 6);
    drive(1'b1, 200);
    expect_count("R9 glitch ignored", base);
    frame(8'h81, 0, 0, 1);
    drive(1'b1, 4);
    expect_count("R9 frame after glitch count", base + 1);
    expect_word("R9 frame after glitch", base, 8'h81, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule